// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is handed on to the host. The receiver fills a four-byte background identifier buffer one byte at a time and then pulses a frame-complete strobe. Every frame lands in that buffer, whether or not it is accepted. On the strobe, the filter compares each buffered identifier byte with a programmable code byte of the same index, bit by bit. Mask bits then remove chosen positions from the comparison. An extended-format frame must pass on all four bytes. A standard-format frame is judged on bytes 0 and 1 only. The identifier-extension flag is bit 3 of buffered byte 1.

An accepted frame pulses a hit output and sets a sticky receive-ready flag that the host clears by writing a one to it. If another frame is accepted while that flag is still set, an overrun flag is raised. A rejected frame raises nothing and is overwritten by the next frame.

Code and mask bytes sit behind a byte-wide register port. They can be read at any time. They can be written only while the init request is high and its acknowledge, which trails the request by one clock, is also high. No frames are filtered while the acknowledge is high.

Top module: `can_accept_filter`

## Requirements
- R1: Every byte written into the background buffer at index k is stored and can be read at register address 12+k, whether the frame is later accepted or rejected.
- R2: A frame with bit 3 of buffered byte 1 set (extended) is accepted only if, in all four bytes, every bit whose mask bit is 0 equals the matching code bit.
- R3: A frame with bit 3 of buffered byte 1 clear (standard) is judged on bytes 0 and 1 only. Bytes 2 and 3 have no effect on the decision.
- R4: A mask bit of 1 makes the identifier bit at that position a don't-care.
- R5: Code bytes are at addresses 0 to 3 and mask bytes at 4 to 7. All of them read back at any time. A write takes effect only when init_req_i and init_ack_o are both 1 at the clock edge; any other write to them is ignored.
- R6: After reset, all code bytes, mask bytes, init_ack_o, hit_o, rx_ready_o and overrun_o are 0.
- R7: init_ack_o equals init_req_i delayed by one clock.
- R8: The decision is registered at the clock edge that samples rx_done_i. After that edge, hit_o is high for exactly one cycle and rx_ready_o is set. No frame is accepted while init_ack_o is 1.
- R9: rx_ready_o stays set until the host writes address 8 with bit 0 set. The status byte at address 8 reads overrun in bit 1 and ready in bit 0.
- R10: overrun_o is set when a frame is accepted while rx_ready_o is already 1. It stays set until address 8 is written with bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_req_i | input | 1 | Init-mode request |
| init_ack_o | output | 1 | Init-mode acknowledge |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| rx_wr_i | input | 1 | Background buffer byte write |
| rx_idx_i | input | 2 | Buffer byte index |
| rx_byte_i | input | 8 | Buffer byte data |
| rx_done_i | input | 1 | Frame-complete strobe |
| hit_o | output | 1 | One-cycle accepted-frame pulse |
| rx_ready_o | output | 1 | Sticky receive-ready flag |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
A code or mask byte that is corrupted, or that takes a write outside the handshake, shows up at the read port on the very next read. It also shows at hit_o on the first frame that exercises the affected bit. A wrong choice of participating bytes gives a wrong hit_o one cycle after the strobe, but only for frames whose unused bytes differ from the code, so the stimulus deliberately includes standard frames with mismatched upper bytes and extended frames that mismatch in byte 2. Flag errors reach the status byte and flag ports at the edge of the next accepted frame or the next clear.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int NB       = 4;
  localparam int BW       = 8;
  localparam int STD_NB   = 2;
  localparam int IDE_BYTE = 1;
  localparam int IDE_BIT  = 3;
  localparam int AW       = 4;
  localparam int IDXW     = $clog2(NB);

  typedef logic [BW-1:0] byte_t;
  typedef byte_t [NB-1:0] bank_t;

  typedef enum logic [1:0] {
    RGN_CODE = 2'd0,
    RGN_MASK = 2'd1,
    RGN_STAT = 2'd2,
    RGN_RXB  = 2'd3
  } region_e;
endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
  import can_filt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  byte_t               wdata_i,
  output logic                init_ack_o,
  output bank_t               code_o,
  output bank_t               mask_o
);
  logic    ack_q;
  bank_t   code_q, mask_q;
  region_e rgn;
  logic    wr_ok;

  assign rgn   = region_e'(addr_i[AW-1 -: 2]);
  assign wr_ok = we_i && init_req_i && ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= init_req_i;
  end

  for (genvar i = 0; i < NB; i++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q[i] <= '0;
        mask_q[i] <= '0;
      end else if (wr_ok && addr_i[IDXW-1:0] == IDXW'(i)) begin
        if (rgn == RGN_CODE) code_q[i] <= wdata_i;
        if (rgn == RGN_MASK) mask_q[i] <= wdata_i;
      end
    end
  end

  assign init_ack_o = ack_q;
  assign code_o     = code_q;
  assign mask_o     = mask_q;

  // R5
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && init_req_i && init_ack_o) |=> ($stable(code_o) && $stable(mask_o)));
  // R7
  ack_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_i |=> init_ack_o);
  // R7
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_req_i |=> !init_ack_o);
endmodule

// File: rtl/can_filt_rxbuf.sv
module can_filt_rxbuf
  import can_filt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [IDXW-1:0] idx_i,
  input  byte_t           byte_i,
  output bank_t           buf_o
);
  bank_t buf_q;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          buf_q[i] <= '0;
      else if (wr_i && idx_i == IDXW'(i))   buf_q[i] <= byte_i;
    end
  end

  assign buf_o = buf_q;

  // R1
  rxbuf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(buf_o));
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
  import can_filt_pkg::*;
(
  input  bank_t id_i,
  input  bank_t code_i,
  input  bank_t mask_i,
  output logic  match_o
);
  logic          ext;
  logic [NB-1:0] miss, used;

  assign ext = id_i[IDE_BYTE][IDE_BIT];

  for (genvar i = 0; i < NB; i++) begin : g_cmp
    assign miss[i] = |((id_i[i] ^ code_i[i]) & ~mask_i[i]);
    if (i < STD_NB) begin : g_std
      assign used[i] = 1'b1;
    end else begin : g_ext
      assign used[i] = ext;
    end
  end

  assign match_o = ~|(miss & used);
endmodule

// File: rtl/can_filt_flags.sv
module can_filt_flags
  import can_filt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic       block_i,
  input  logic       match_i,
  input  logic [1:0] clr_i,
  output logic       hit_o,
  output logic       ready_o,
  output logic       ovr_o
);
  logic accept, hit_q, ready_q, ovr_q;

  assign accept = done_i && !block_i && match_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      hit_q   <= accept;
      ready_q <= accept || (ready_q && !clr_i[0]);
      ovr_q   <= (accept && ready_q) || (ovr_q && !clr_i[1]);
    end
  end

  assign hit_o   = hit_q;
  assign ready_o = ready_q;
  assign ovr_o   = ovr_q;

  // R8
  ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(done_i && !block_i));
  // R8
  init_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && block_i) |=> !hit_o);
  // R10
  ovr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(ready_o));
  // R9
  ready_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[0] && !done_i) |=> !ready_o);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_req_i,
  output logic            init_ack_o,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [BW-1:0]   reg_wdata_i,
  output logic [BW-1:0]   reg_rdata_o,
  input  logic            rx_wr_i,
  input  logic [IDXW-1:0] rx_idx_i,
  input  logic [BW-1:0]   rx_byte_i,
  input  logic            rx_done_i,
  output logic            hit_o,
  output logic            rx_ready_o,
  output logic            overrun_o
);
  bank_t           code, mask, rxb;
  logic            match;
  logic [1:0]      clr;
  region_e         rgn;
  logic [IDXW-1:0] idx;

  assign rgn = region_e'(reg_addr_i[AW-1 -: 2]);
  assign idx = reg_addr_i[IDXW-1:0];
  assign clr = (reg_we_i && rgn == RGN_STAT) ? reg_wdata_i[1:0] : 2'b00;

  can_filt_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_req_i (init_req_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .init_ack_o (init_ack_o),
    .code_o     (code),
    .mask_o     (mask)
  );

  can_filt_rxbuf u_rxbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (rx_wr_i),
    .idx_i  (rx_idx_i),
    .byte_i (rx_byte_i),
    .buf_o  (rxb)
  );

  can_filt_match u_match (
    .id_i    (rxb),
    .code_i  (code),
    .mask_i  (mask),
    .match_o (match)
  );

  can_filt_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (rx_done_i),
    .block_i (init_ack_o),
    .match_i (match),
    .clr_i   (clr),
    .hit_o   (hit_o),
    .ready_o (rx_ready_o),
    .ovr_o   (overrun_o)
  );

  always_comb begin
    unique case (rgn)
      RGN_CODE: reg_rdata_o = code[idx];
      RGN_MASK: reg_rdata_o = mask[idx];
      RGN_STAT: reg_rdata_o = {{(BW-2){1'b0}}, overrun_o, rx_ready_o};
      default:  reg_rdata_o = rxb[idx];
    endcase
  end

  // R8
  hit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !rx_done_i) |=> !hit_o);
endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_req = 1'b0;
  logic       init_ack;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_wr = 1'b0;
  logic [1:0] rx_idx = '0;
  logic [7:0] rx_byte = '0;
  logic       rx_done = 1'b0;
  logic       hit, ready, ovr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit exp_q[$];
  logic pend = 1'b0;

  always #2.5 clk = ~clk;

  can_accept_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .init_req_i(init_req), .init_ack_o(init_ack),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_wr_i(rx_wr), .rx_idx_i(rx_idx), .rx_byte_i(rx_byte), .rx_done_i(rx_done),
    .hit_o(hit), .rx_ready_o(ready), .overrun_o(ovr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a; #0.5;
    chk(req, rdata, exp);
  endtask

  // driver: loads buffer, strobes, pushes expected hit
  task automatic frame(input logic [7:0] b0, b1, b2, b3, input bit exp_hit);
    logic [7:0] bytes [4];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); rx_wr = 1'b1; rx_idx = 2'(k); rx_byte = bytes[k];
    end
    @(negedge clk); rx_wr = 1'b0; rx_done = 1'b1;
    exp_q.push_back(exp_hit);
    @(negedge clk); rx_done = 1'b0;
  endtask

  // monitor
  always @(posedge clk) pend <= rx_done;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk("R8 unexpected", 8'(hit), 8'hxx);
      else chk("R2/R3/R4/R8 hit", 8'(hit), 8'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    chk("R6 ack", 8'(init_ack), 8'h0);
    chk("R6 hit", 8'(hit), 8'h0);
    rd("R6 code0", 4'd0, 8'h00);
    rd("R6 mask3", 4'd7, 8'h00);
    rd("R6 status", 4'd8, 8'h00);

    // R5 write outside init ignored
    wr(4'd0, 8'hAA);
    rd("R5 no-init write", 4'd0, 8'h00);

    // R5/R7 write in the request cycle (ack still 0) ignored
    @(negedge clk); init_req = 1'b1; we = 1'b1; addr = 4'd3; wdata = 8'h55;
    @(negedge clk); we = 1'b0;
    chk("R7 ack after one clock", 8'(init_ack), 8'h1);
    rd("R5 write before ack", 4'd3, 8'h00);

    wr(4'd0, 8'h12); wr(4'd1, 8'h38); wr(4'd2, 8'h56); wr(4'd3, 8'h78);
    wr(4'd4, 8'h00); wr(4'd5, 8'h08); wr(4'd6, 8'h00); wr(4'd7, 8'h0F);
    rd("R5 code1", 4'd1, 8'h38);
    rd("R5 mask3", 4'd7, 8'h0F);

    // R8 no filtering during init
    frame(8'h12, 8'h38, 8'h56, 8'h78, 1'b0);
    rd("R8 ready during init", 4'd8, 8'h00);

    @(negedge clk); init_req = 1'b0;
    @(negedge clk);
    chk("R7 ack drops", 8'(init_ack), 8'h0);
    wr(4'd2, 8'hEE);
    rd("R5 write after exit", 4'd2, 8'h56);

    // R2 R4 extended, byte3 low nibble masked
    frame(8'h12, 8'h38, 8'h56, 8'h7A, 1'b1);
    @(negedge clk);
    rd("R9 ready set", 4'd8, 8'h01);
    chk("R9 ready port", 8'(ready), 8'h1);
    // R2 extended mismatch in byte2
    frame(8'h12, 8'h38, 8'h57, 8'h78, 1'b0);
    rd("R1 rejected byte kept", 4'd14, 8'h57);
    rd("R1 byte1", 4'd13, 8'h38);
    // R2 extended mismatch in byte2 on 0xFF
    frame(8'h12, 8'h38, 8'hFF, 8'h78, 1'b0);
    rd("R10 no overrun on reject", 4'd8, 8'h01);
    // R3 standard, bytes 2/3 ignored; accepted while ready set
    frame(8'h12, 8'h30, 8'hFF, 8'hFF, 1'b1);
    @(negedge clk);
    rd("R10 overrun set", 4'd8, 8'h03);
    chk("R10 overrun port", 8'(ovr), 8'h1);
    // R3 standard mismatch in byte0
    frame(8'h13, 8'h30, 8'h56, 8'h78, 1'b0);
    // R4 mask bit in byte1 covers IDE
    rd("R4 mask1", 4'd5, 8'h08);

    // R9 clear ready only
    wr(4'd8, 8'h01);
    rd("R9 ready cleared", 4'd8, 8'h02);
    // R10 clear overrun
    wr(4'd8, 8'h02);
    rd("R10 overrun cleared", 4'd8, 8'h00);
    // R10 accept with ready clear: no overrun
    frame(8'h12, 8'h38, 8'h56, 8'h71, 1'b1);
    @(negedge clk);
    rd("R10 single accept", 4'd8, 8'h01);

    repeat (3) @(negedge clk);
    chk("R8 queue drained", 8'(exp_q.size()), 8'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule